// File: doc/BRIEF.md
# Shared-Memory Byte Ring Accessor

This block moves single bytes into and out of a circular buffer that lives in an external memory shared with a second processor. The ring is described by three bytes placed directly below the buffer base: the wrap mask (ring length minus one) at base-3, the producer index at base-2 and the consumer index at base-1. After an initialise command copies these three bytes into local registers, the block keeps its own copies of the mask and both indices. On every transfer it reads only the index that the other side owns, so it can tell whether the ring is empty or full, and it writes back the index it owns once the transfer is complete.

The command side takes one command at a time: initialise with a base address, get a byte, or put a byte. Each get or put may be blocking, in which case the peer index is polled until data or space appears. A base of zero marks the ring as unconfigured. All memory traffic goes through a single request/acknowledge port. A request is held until it is acknowledged, and read data is taken in the acknowledge cycle. Obtaining ownership of the shared bus is left to the surrounding system.

State machine: `ST_IDLE` accepts a command. `ST_INIT_MASK` → `ST_INIT_IN` → `ST_INIT_OUT` → `ST_IDLE` loads the descriptor. `ST_GET_PEEK` reads the producer index, then either loops (blocking and empty), returns to `ST_IDLE` (non-blocking and empty), or goes on to `ST_GET_DATA` → `ST_GET_IDX` → `ST_IDLE`. `ST_PUT_PEEK` reads the consumer index, then either loops (blocking and full), returns to `ST_IDLE` (non-blocking and full), or goes on to `ST_PUT_DATA` → `ST_PUT_IDX` → `ST_IDLE`. Each memory state advances only in the cycle in which `mem_ack` is high.

Top module: `shmem_ring_port`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are 0 and the ring is unconfigured (base 0).
- R2: An initialise command (`cmd_op`=0) with a nonzero `cmd_base` reads base-3, base-2 and base-1 in that order, keeps the results as mask, producer index and consumer index, and then pulses `done`. With `cmd_base`=0 it makes no memory access and pulses `done` in the cycle after acceptance.
- R3: A get (`cmd_op`=1) first reads base-2, and treats the ring as empty when that byte equals the local consumer index.
- R4: A get on a non-empty ring reads base + consumer index and returns that byte on `rsp_rdata` with `done`. It then writes (consumer index + 1) AND mask to base-1 and keeps that value as the new local consumer index.
- R5: A non-blocking get (`cmd_wait`=0) on an empty ring ends with `done` and `rsp_nodata`=1, after exactly one memory read.
- R6: A blocking get (`cmd_wait`=1) on an empty ring reads base-2 again after each acknowledge until the ring is non-empty, and then completes as in R4.
- R7: A put (`cmd_op`=2) first reads base-1, and treats the ring as full when (local producer index + 1) AND mask equals that byte.
- R8: A put on a non-full ring writes `cmd_wdata` to base + producer index, and after that writes (producer index + 1) AND mask to base-2. The index therefore wraps to 0 past the mask.
- R9: A non-blocking put on a full ring ends with `done` and `rsp_full`=1, after exactly one read. A blocking put on a full ring re-reads base-1 until space appears, and then completes as in R8.
- R10: While the ring is unconfigured, a get ends at once with `rsp_nodata`=1 and a put ends at once with `rsp_full`=0, and neither makes any memory access.
- R11: `busy` is 1 from the cycle after acceptance until `done`. A command presented while `busy` is 1 is ignored.
- R12: Once `mem_req` is raised, it stays high with the same `mem_addr` and `mem_we` until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_op | input | 2 | 0 initialise, 1 get, 2 put, 3 ignored |
| cmd_wait | input | 1 | 1 makes a get or put poll until it can complete |
| cmd_base | input | AW | Ring base address for initialise |
| cmd_wdata | input | 8 | Byte to put |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte returned by a successful get |
| rsp_nodata | output | 1 | With done: get found ring empty or unconfigured |
| rsp_full | output | 1 | With done: non-blocking put found ring full |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Access completes in this cycle |
| mem_rdata | input | 8 | Read data, valid with mem_ack |

## Verification
Two pairs of events can fall in the same cycle. The first is a new command arriving while an earlier one still has accesses outstanding. The second is the peer changing its index while a blocking poll is re-reading that index. The bench raises an initialise strobe in the cycle after a get has been accepted, and checks against a queue of expected accesses that no extra access appears and that no local state changes. The bench's memory model rewrites the polled index after a chosen number of reads. The access queue then has to show exactly that many repeated reads, followed by the data and index accesses.

// File: rtl/shmem_ring_pkg.sv
package shmem_ring_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_INIT_MASK,
        ST_INIT_IN,
        ST_INIT_OUT,
        ST_GET_PEEK,
        ST_GET_DATA,
        ST_GET_IDX,
        ST_PUT_PEEK,
        ST_PUT_DATA,
        ST_PUT_IDX
    } ring_state_e;

    typedef enum logic [1:0] {
        OP_INIT = 2'd0,
        OP_GET  = 2'd1,
        OP_PUT  = 2'd2
    } ring_op_e;

    typedef enum logic [1:0] {
        SEL_SLOT,
        SEL_MASK,
        SEL_INIDX,
        SEL_OUTIDX
    } addr_sel_e;
endpackage

// File: rtl/shmem_ring_addr.sv
module shmem_ring_addr
    import shmem_ring_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic [AW-1:0] base,
    input  addr_sel_e     sel,
    input  logic [DW-1:0] idx,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] OFS_MASK = AW'(3);
    localparam logic [AW-1:0] OFS_IN   = AW'(2);
    localparam logic [AW-1:0] OFS_OUT  = AW'(1);

    always_comb begin
        unique case (sel)
            SEL_MASK:   addr = base - OFS_MASK;
            SEL_INIDX:  addr = base - OFS_IN;
            SEL_OUTIDX: addr = base - OFS_OUT;
            default:    addr = base + AW'(idx);
        endcase
    end
endmodule

// File: rtl/shmem_ring_step.sv
module shmem_ring_step #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] idx,
    input  logic [DW-1:0] mask,
    output logic [DW-1:0] nxt
);
    always_comb nxt = (idx + DW'(1)) & mask;
endmodule

// File: rtl/shmem_ring_port.sv
module shmem_ring_port
    import shmem_ring_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic          cmd_wait,
    input  logic [AW-1:0] cmd_base,
    input  logic [DW-1:0] cmd_wdata,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_nodata,
    output logic          rsp_full,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);
    ring_state_e   state, state_n;
    logic [AW-1:0] base_q;
    logic [DW-1:0] mask_q, in_q, out_q, wdata_q;
    logic          wait_q;
    logic [DW-1:0] in_nxt, out_nxt, slot_idx;
    addr_sel_e     sel;
    logic          unconf, accept, peer_empty, peer_full;

    shmem_ring_step #(.DW(DW)) u_step_in  (.idx(in_q),  .mask(mask_q), .nxt(in_nxt));
    shmem_ring_step #(.DW(DW)) u_step_out (.idx(out_q), .mask(mask_q), .nxt(out_nxt));
    shmem_ring_addr #(.AW(AW), .DW(DW)) u_addr (
        .base(base_q), .sel(sel), .idx(slot_idx), .addr(mem_addr)
    );

    assign unconf     = (base_q == '0);
    assign accept     = (state == ST_IDLE) && cmd_valid;
    assign peer_empty = (mem_rdata == out_q);
    assign peer_full  = (in_nxt == mem_rdata);
    assign busy       = (state != ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next-state decision
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (cmd_valid) begin
                unique case (cmd_op)
                    OP_INIT: state_n = (cmd_base == '0) ? ST_IDLE : ST_INIT_MASK;
                    OP_GET:  state_n = unconf ? ST_IDLE : ST_GET_PEEK;
                    OP_PUT:  state_n = unconf ? ST_IDLE : ST_PUT_PEEK;
                    default: state_n = ST_IDLE;
                endcase
            end
            ST_INIT_MASK: if (mem_ack) state_n = ST_INIT_IN;
            ST_INIT_IN:   if (mem_ack) state_n = ST_INIT_OUT;
            ST_INIT_OUT:  if (mem_ack) state_n = ST_IDLE;
            ST_GET_PEEK:  if (mem_ack) state_n = !peer_empty ? ST_GET_DATA
                                               : (wait_q ? ST_GET_PEEK : ST_IDLE);
            ST_GET_DATA:  if (mem_ack) state_n = ST_GET_IDX;
            ST_GET_IDX:   if (mem_ack) state_n = ST_IDLE;
            ST_PUT_PEEK:  if (mem_ack) state_n = !peer_full ? ST_PUT_DATA
                                               : (wait_q ? ST_PUT_PEEK : ST_IDLE);
            ST_PUT_DATA:  if (mem_ack) state_n = ST_PUT_IDX;
            ST_PUT_IDX:   if (mem_ack) state_n = ST_IDLE;
            default:      state_n = ST_IDLE;
        endcase
    end

    // memory port drive, decoded from the state
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_wdata = '0;
        sel       = SEL_MASK;
        slot_idx  = out_q;
        unique case (state)
            ST_INIT_MASK:            sel = SEL_MASK;
            ST_INIT_IN, ST_GET_PEEK: sel = SEL_INIDX;
            ST_INIT_OUT, ST_PUT_PEEK: sel = SEL_OUTIDX;
            ST_GET_DATA: begin sel = SEL_SLOT; slot_idx = out_q; end
            ST_GET_IDX:  begin sel = SEL_OUTIDX; mem_we = 1'b1; mem_wdata = out_nxt; end
            ST_PUT_DATA: begin sel = SEL_SLOT; slot_idx = in_q; mem_we = 1'b1; mem_wdata = wdata_q; end
            ST_PUT_IDX:  begin sel = SEL_INIDX; mem_we = 1'b1; mem_wdata = in_nxt; end
            default:     mem_req = 1'b0;
        endcase
    end

    // local ring copy and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0; mask_q <= '0; in_q <= '0; out_q <= '0;
            wdata_q <= '0; wait_q <= 1'b0;
            done <= 1'b0; rsp_rdata <= '0; rsp_nodata <= 1'b0; rsp_full <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                wait_q  <= cmd_wait;
                wdata_q <= cmd_wdata;
                unique case (cmd_op)
                    OP_INIT: begin
                        base_q <= cmd_base;
                        mask_q <= '0; in_q <= '0; out_q <= '0;
                        if (cmd_base == '0) begin
                            done <= 1'b1; rsp_nodata <= 1'b0; rsp_full <= 1'b0;
                        end
                    end
                    OP_GET: if (unconf) begin
                        done <= 1'b1; rsp_nodata <= 1'b1; rsp_full <= 1'b0;
                    end
                    OP_PUT: if (unconf) begin
                        done <= 1'b1; rsp_nodata <= 1'b0; rsp_full <= 1'b0;
                    end
                    default: ;
                endcase
            end else if (mem_ack) begin
                unique case (state)
                    ST_INIT_MASK: mask_q <= mem_rdata;
                    ST_INIT_IN:   in_q   <= mem_rdata;
                    ST_INIT_OUT: begin
                        out_q <= mem_rdata;
                        done <= 1'b1; rsp_nodata <= 1'b0; rsp_full <= 1'b0;
                    end
                    ST_GET_PEEK: if (peer_empty && !wait_q) begin
                        done <= 1'b1; rsp_nodata <= 1'b1; rsp_full <= 1'b0;
                    end
                    ST_GET_DATA: rsp_rdata <= mem_rdata;
                    ST_GET_IDX: begin
                        out_q <= out_nxt;
                        done <= 1'b1; rsp_nodata <= 1'b0; rsp_full <= 1'b0;
                    end
                    ST_PUT_PEEK: if (peer_full && !wait_q) begin
                        done <= 1'b1; rsp_nodata <= 1'b0; rsp_full <= 1'b1;
                    end
                    ST_PUT_IDX: begin
                        in_q <= in_nxt;
                        done <= 1'b1; rsp_nodata <= 1'b0; rsp_full <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R12
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R11
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(rsp_nodata && rsp_full)); // R5
    AST_INDEX_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUT_IDX) |-> ($past(state) == ST_PUT_DATA || $past(state) == ST_PUT_IDX)); // R8
    AST_UNCONF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        unconf |-> !mem_req); // R10
endmodule

// File: tb/shmem_ring_port_tb.sv
module shmem_ring_port_tb;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic          cmd_wait = 1'b0;
    logic [AW-1:0] cmd_base = '0;
    logic [7:0]    cmd_wdata = '0;
    logic          busy, done, rsp_nodata, rsp_full, mem_req, mem_we;
    logic [7:0]    rsp_rdata, mem_wdata;
    logic [AW-1:0] mem_addr;
    logic          mem_ack = 1'b0;
    logic [7:0]    mem_rdata = '0;

    shmem_ring_port #(.AW(AW), .DW(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wait(cmd_wait), .cmd_base(cmd_base), .cmd_wdata(cmd_wdata),
        .busy(busy), .done(done), .rsp_rdata(rsp_rdata), .rsp_nodata(rsp_nodata),
        .rsp_full(rsp_full), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #10 clk = ~clk;

    int errors = 0;
    int checks = 0;
    string cur_rq = "R1";

    task automatic chk(bit ok, string rq, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // behavioural memory and reference ring state
    logic [7:0] mem [int];
    int exp_addr[$];
    int exp_we[$];
    int exp_dat[$];
    int m_base = 0, m_mask = 0, m_in = 0, m_out = 0;
    int lat = 0, acc_cnt = 0, held_addr = 0;
    int peer_addr = 0, peer_after = 0, peer_val = 0, peer_cnt = 0;
    bit peer_armed = 1'b0;

    function automatic int wrapa(int x);
        return x & ((1 << AW) - 1);
    endfunction
    function automatic int rd(int x);
        if (mem.exists(wrapa(x))) return int'(mem[wrapa(x)]);
        return 0;
    endfunction
    task automatic push(int ad, int we, int d);
        exp_addr.push_back(wrapa(ad)); exp_we.push_back(we); exp_dat.push_back(d);
    endtask

    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            acc_cnt = 0;
        end else if (mem_req) begin
            if (acc_cnt == 0) held_addr = int'(mem_addr);
            else chk(int'(mem_addr) == held_addr, "R12", "address held", int'(mem_addr), held_addr);
            if (acc_cnt >= lat) begin
                if (exp_addr.size() == 0) begin
                    chk(1'b0, cur_rq, "unexpected access", int'(mem_addr), -1);
                end else begin
                    int ea, ew, ed;
                    ea = exp_addr.pop_front(); ew = exp_we.pop_front(); ed = exp_dat.pop_front();
                    chk(int'(mem_addr) == ea, cur_rq, "access address", int'(mem_addr), ea);
                    chk(int'(mem_we) == ew, cur_rq, "access direction", int'(mem_we), ew);
                    if (ew == 1) chk(int'(mem_wdata) == ed, cur_rq, "write data", int'(mem_wdata), ed);
                end
                if (mem_we) mem[int'(mem_addr)] = mem_wdata;
                else begin
                    mem_rdata = 8'(rd(int'(mem_addr)));
                    if (peer_armed && int'(mem_addr) == peer_addr) begin
                        peer_cnt++;
                        if (peer_cnt == peer_after) begin
                            mem[peer_addr] = 8'(peer_val);
                            peer_armed = 1'b0;
                        end
                    end
                end
                mem_ack = 1'b1;
                lat = (lat + 1) % 3;
            end else acc_cnt++;
        end
    end

    task automatic run_cmd(int op, bit wt, int base, int wd, bit enod, bit efull,
                           int edata, bit cdata, bit intr, string rq);
        int n;
        cur_rq = rq;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_wait = wt;
        cmd_base = AW'(base); cmd_wdata = 8'(wd);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (intr) begin
            // R11: a strobe while the operation runs must be ignored
            cmd_valid = 1'b1; cmd_op = 2'd0; cmd_base = AW'(12'h300);
            chk(busy == 1'b1, "R11", "busy after accept", int'(busy), 1);
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        n = 0;
        while (!done && n < 3000) begin
            chk(busy == 1'b1, "R11", "busy while running", int'(busy), 1);
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, rq, "completion", int'(done), 1);
        chk(busy == 1'b0, "R11", "idle at done", int'(busy), 0);
        chk(rsp_nodata == enod, rq, "nodata flag", int'(rsp_nodata), int'(enod));
        chk(rsp_full == efull, rq, "full flag", int'(rsp_full), int'(efull));
        if (cdata) chk(int'(rsp_rdata) == edata, rq, "read byte", int'(rsp_rdata), edata);
        chk(exp_addr.size() == 0, rq, "missing accesses", exp_addr.size(), 0);
        exp_addr.delete(); exp_we.delete(); exp_dat.delete();
    endtask

    task automatic m_init(int base, string rq);
        if (base != 0) begin
            push(base - 3, 0, 0); push(base - 2, 0, 0); push(base - 1, 0, 0);
            m_mask = rd(base - 3); m_in = rd(base - 2); m_out = rd(base - 1);
        end else begin
            m_mask = 0; m_in = 0; m_out = 0;
        end
        m_base = base;
        run_cmd(0, 1'b0, base, 0, 1'b0, 1'b0, 0, 1'b0, 1'b0, rq);
    endtask

    task automatic m_get(bit wt, int polls, int newin, bit intr, string rq);
        int cur, d, nxt;
        if (m_base == 0) begin
            run_cmd(1, wt, 0, 0, 1'b1, 1'b0, 0, 1'b0, 1'b0, rq);
            return;
        end
        cur = rd(m_base - 2);
        if (cur == m_out && !wt) begin
            push(m_base - 2, 0, 0);
            run_cmd(1, wt, 0, 0, 1'b1, 1'b0, 0, 1'b0, intr, rq);
            return;
        end
        if (cur == m_out) begin
            peer_addr = wrapa(m_base - 2); peer_after = polls; peer_val = newin;
            peer_cnt = 0; peer_armed = 1'b1;
            repeat (polls) push(m_base - 2, 0, 0);
        end
        push(m_base - 2, 0, 0);
        d = rd(m_base + m_out);
        push(m_base + m_out, 0, 0);
        nxt = (m_out + 1) & m_mask;
        push(m_base - 1, 1, nxt);
        m_out = nxt;
        run_cmd(1, wt, 0, 0, 1'b0, 1'b0, d, 1'b1, intr, rq);
    endtask

    task automatic m_put(bit wt, int data, int polls, int newout, string rq);
        int cur, nxt;
        if (m_base == 0) begin
            run_cmd(2, wt, 0, data, 1'b0, 1'b0, 0, 1'b0, 1'b0, rq);
            return;
        end
        cur = rd(m_base - 1);
        nxt = (m_in + 1) & m_mask;
        if (nxt == cur && !wt) begin
            push(m_base - 1, 0, 0);
            run_cmd(2, wt, 0, data, 1'b0, 1'b1, 0, 1'b0, 1'b0, rq);
            return;
        end
        if (nxt == cur) begin
            peer_addr = wrapa(m_base - 1); peer_after = polls; peer_val = newout;
            peer_cnt = 0; peer_armed = 1'b1;
            repeat (polls) push(m_base - 1, 0, 0);
        end
        push(m_base - 1, 0, 0);
        push(m_base + m_in, 1, data);
        push(m_base - 2, 1, nxt);
        m_in = nxt;
        run_cmd(2, wt, 0, data, 1'b0, 1'b0, 0, 1'b0, 1'b0, rq);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, cur_rq, "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        mem[12'h0FD] = 8'h07; mem[12'h0FE] = 8'h00; mem[12'h0FF] = 8'h00;
        mem[12'h1FD] = 8'h03; mem[12'h1FE] = 8'h01; mem[12'h1FF] = 8'h01;
        mem[12'h201] = 8'h77;
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
        chk(done == 1'b0, "R1", "done in reset", int'(done), 0);
        chk(mem_req == 1'b0, "R1", "mem_req in reset", int'(mem_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_req == 1'b0, "R1", "quiet after reset", int'(mem_req), 0);

        m_get(1'b0, 0, 0, 1'b0, "R10");          // unconfigured get
        m_get(1'b1, 0, 0, 1'b0, "R10");          // unconfigured blocking get
        m_put(1'b0, 8'h11, 0, 0, "R10");         // unconfigured put
        m_init(12'h100, "R2");
        m_get(1'b0, 0, 0, 1'b0, "R5");           // empty, non-blocking
        m_put(1'b0, 8'hA1, 0, 0, "R8");
        m_put(1'b1, 8'hB2, 0, 0, "R8");
        m_get(1'b0, 0, 0, 1'b0, "R4");
        m_get(1'b0, 0, 0, 1'b1, "R11");          // strobe while busy
        m_get(1'b0, 0, 0, 1'b0, "R3");           // empty again
        for (int k = 0; k < 7; k++) m_put(1'b0, 8'hC0 + k, 0, 0, "R8");  // wraps 7 -> 0
        chk(m_in == 1, "R8", "model wrap point", m_in, 1);
        m_put(1'b0, 8'hDD, 0, 0, "R9");          // full, non-blocking
        m_put(1'b1, 8'hEE, 2, 3, "R9");          // full, peer frees space
        m_put(1'b0, 8'h5A, 0, 0, "R7");          // full test against new peer index
        m_init(12'h200, "R2");
        m_get(1'b1, 3, 2, 1'b0, "R6");           // blocking, peer fills after polls
        m_get(1'b0, 0, 0, 1'b0, "R3");
        m_init(0, "R2");
        m_get(1'b0, 0, 0, 1'b0, "R10");
        repeat (3) @(negedge clk);
        chk(mem_req == 1'b0, "R10", "no access when unconfigured", int'(mem_req), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule